// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for indirect operand accesses. It has three files of pointer state: index registers, modify registers and length registers. Each file holds four 14-bit entries. On every access, the selected index register drives the memory address. The index register is then post-modified by a modify register, which is chosen independently. A length register of zero gives plain linear stepping. A nonzero length confines the pointer to a circular buffer of that many words.

A parameter selects one of two variants. The data-only variant (`DUAL_MEM = 0`) drives only the data-memory address. While the bit-reverse mode input is high, it presents that address with all 14 bits reversed, which serves FFT-style reordering. The dual variant (`DUAL_MEM = 1`) sends each access to either the program-memory or the data-memory address port and never reverses bits. Software loads and reads back all twelve registers over a 16-bit bus. Instruction decode, the memories and bus arbitration sit outside the block.

Top module: `addrgen`

## Requirements
- R1: After reset, every index, modify and length register reads back as zero.
- R2: A bus write stores the lower 14 bits of `busWrData` into the register chosen by `busFile` (0 = index, 1 = modify, 2 = length) and `busIdx`. `busRdData` returns the register chosen by the same two inputs, with bits 15:14 at zero. File code 3 reads as zero and a write to it changes nothing.
- R3: During an access, the address output carries the selected index register's value from before the update, in the same cycle, with its valid flag high.
- R4: With the pointer's length register at zero, the index becomes I + M modulo 2^14 at the clock edge. M is a 14-bit two's-complement value.
- R5: With a nonzero length L, the buffer base is I with its low ceil(log2 L) bits cleared. If I + M reaches base + L or beyond, L is subtracted. If I + M falls below base, L is added. This holds for |M| <= L.
- R6: If a bus write targets the same index register that an access updates in that cycle, the bus value is the one kept.
- R7: In the data-only variant, while `bitRevMode` is high, the data address is the index with bit 0 and bit 13 swapped, bit 1 and bit 12 swapped, and so on. The stored index is updated without reversal.
- R8: In the dual variant, `accToPm = 1` sends the access to `pmAddr`/`pmValid` only, and `accToPm = 0` sends it to `dmAddr`/`dmValid` only. `bitRevMode` has no effect. The data-only variant ignores `accToPm` and never raises `pmValid`.
- R9: Without `accessEn`, both valid flags are low, both addresses are zero, and no index register changes.
- R10: The modify register is selected by `accMod`, independently of the pointer chosen by `accPtr`. The length register used is always the one paired with the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busFile | input | 2 | Register file select: 0 index, 1 modify, 2 length |
| busIdx | input | 2 | Register number within the file |
| busWrData | input | 16 | Write data (lower 14 bits used) |
| busRdData | output | 16 | Read data for the selected register |
| accessEn | input | 1 | Perform an address access this cycle |
| accPtr | input | 2 | Index register used for the access |
| accMod | input | 2 | Modify register used for the access |
| accToPm | input | 1 | Send the access to program memory (dual variant) |
| bitRevMode | input | 1 | Reverse data addresses (data-only variant) |
| dmAddr | output | 14 | Data-memory address |
| dmValid | output | 1 | Data-memory address valid |
| pmAddr | output | 14 | Program-memory address |
| pmValid | output | 1 | Program-memory address valid |

## Verification
The checker watches every cycle for four things: the two valid flags never rise together, the outputs stay quiet while idle, the read bus never drives bits 15:14, and the data-only variant never raises `pmValid`. It also confirms that each linear access leaves the pointer holding I + M on the next cycle. Circular wrapping in both directions, the effect of reversal on the output but not on stored state, the collision rule and the routing between the two memory ports can only be seen in the bench's scenarios. Those scenarios include a table-driven walk around a five-word buffer that mixes positive and negative modify values.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;
  localparam int ADDR_W  = 14;
  localparam int BUS_W   = 16;
  localparam int NUM_PTR = 4;
  localparam int SEL_W   = $clog2(NUM_PTR);

  typedef enum logic [1:0] {
    FILE_IDX  = 2'd0,
    FILE_MOD  = 2'd1,
    FILE_LEN  = 2'd2,
    FILE_NONE = 2'd3
  } regFile_e;

  typedef struct packed {
    logic [NUM_PTR-1:0] wrIdx;
    logic [NUM_PTR-1:0] wrMod;
    logic [NUM_PTR-1:0] wrLen;
    logic [NUM_PTR-1:0] updIdx;
    logic [SEL_W-1:0]   ptrSel;
    logic [SEL_W-1:0]   modSel;
    logic               outEn;
    logic               toPm;
    logic               revOut;
  } strobes_t;
endpackage

// File: rtl/addrgen_ctrl.sv
module addrgen_ctrl
  import addrgen_pkg::*;
#(
  parameter bit DUAL_MEM = 1'b0
) (
  input  logic             busWrEn,
  input  logic [1:0]       busFile,
  input  logic [SEL_W-1:0] busIdx,
  input  logic             accessEn,
  input  logic [SEL_W-1:0] accPtr,
  input  logic [SEL_W-1:0] accMod,
  input  logic             accToPm,
  input  logic             bitRevMode,
  output strobes_t         stb
);
  regFile_e fileSel;
  logic     pmRoute;
  logic     revRoute;

  assign fileSel = regFile_e'(busFile);

  generate
    if (DUAL_MEM) begin : g_dual
      assign pmRoute  = accToPm;
      assign revRoute = 1'b0;
    end else begin : g_dataOnly
      assign pmRoute  = 1'b0;
      assign revRoute = bitRevMode;
    end
  endgenerate

  always_comb begin
    stb = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      stb.wrIdx[i]  = busWrEn && (fileSel == FILE_IDX) && (busIdx == SEL_W'(i));
      stb.wrMod[i]  = busWrEn && (fileSel == FILE_MOD) && (busIdx == SEL_W'(i));
      stb.wrLen[i]  = busWrEn && (fileSel == FILE_LEN) && (busIdx == SEL_W'(i));
      stb.updIdx[i] = accessEn && (accPtr == SEL_W'(i)) && !stb.wrIdx[i];
    end
    stb.ptrSel = accPtr;
    stb.modSel = accMod;
    stb.outEn  = accessEn;
    stb.toPm   = pmRoute;
    stb.revOut = revRoute;
  end
endmodule

// File: rtl/addrgen_dp.sv
module addrgen_dp
  import addrgen_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobes_t                        stb,
  input  logic [1:0]                      busFile,
  input  logic [SEL_W-1:0]                busIdx,
  input  logic [BUS_W-1:0]                busWrData,
  output logic [BUS_W-1:0]                busRdData,
  output logic [ADDR_W-1:0]               dmAddr,
  output logic                            dmValid,
  output logic [ADDR_W-1:0]               pmAddr,
  output logic                            pmValid,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  idxFile,
  output logic [ADDR_W-1:0]               modCur,
  output logic [ADDR_W-1:0]               lenCur
);
  localparam int EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0] idxRegs [NUM_PTR];
  logic [ADDR_W-1:0] modRegs [NUM_PTR];
  logic [ADDR_W-1:0] lenRegs [NUM_PTR];
  logic [ADDR_W-1:0] idxCur, nextIdx, baseAddr, outAddr, revAddr, lowMask;
  logic signed [EXT_W-1:0] sumExt, baseExt, endExt, lenExt;

  function automatic logic [ADDR_W-1:0] maskFor(input logic [ADDR_W-1:0] len);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int k = 0; k < ADDR_W; k++)
      if ((ADDR_W+1)'(len) > ((ADDR_W+1)'(1) << k)) m[k] = 1'b1;
    return m;
  endfunction

  assign idxCur   = idxRegs[stb.ptrSel];
  assign modCur   = modRegs[stb.modSel];
  assign lenCur   = lenRegs[stb.ptrSel];
  assign lowMask  = maskFor(lenCur);
  assign baseAddr = idxCur & ~lowMask;

  always_comb begin
    sumExt  = $signed({2'b00, idxCur}) + $signed({{2{modCur[ADDR_W-1]}}, modCur});
    baseExt = $signed({2'b00, baseAddr});
    lenExt  = $signed({2'b00, lenCur});
    endExt  = baseExt + lenExt;
    if (lenCur == '0)            nextIdx = sumExt[ADDR_W-1:0];
    else if (sumExt >= endExt)   nextIdx = ADDR_W'(sumExt - lenExt);
    else if (sumExt < baseExt)   nextIdx = ADDR_W'(sumExt + lenExt);
    else                         nextIdx = sumExt[ADDR_W-1:0];
  end

  genvar g;
  generate
    for (g = 0; g < ADDR_W; g++) begin : g_rev
      assign revAddr[g] = idxCur[ADDR_W-1-g];
    end
    for (g = 0; g < NUM_PTR; g++) begin : g_regs
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          idxRegs[g] <= '0;
          modRegs[g] <= '0;
          lenRegs[g] <= '0;
        end else begin
          if (stb.wrIdx[g])       idxRegs[g] <= busWrData[ADDR_W-1:0];
          else if (stb.updIdx[g]) idxRegs[g] <= nextIdx;
          if (stb.wrMod[g])       modRegs[g] <= busWrData[ADDR_W-1:0];
          if (stb.wrLen[g])       lenRegs[g] <= busWrData[ADDR_W-1:0];
        end
      end
      assign idxFile[g] = idxRegs[g];
    end
  endgenerate

  assign outAddr = stb.revOut ? revAddr : idxCur;
  assign dmValid = stb.outEn && !stb.toPm;
  assign pmValid = stb.outEn && stb.toPm;
  assign dmAddr  = dmValid ? outAddr : '0;
  assign pmAddr  = pmValid ? idxCur : '0;

  always_comb begin
    unique case (regFile_e'(busFile))
      FILE_IDX: busRdData = BUS_W'(idxRegs[busIdx]);
      FILE_MOD: busRdData = BUS_W'(modRegs[busIdx]);
      FILE_LEN: busRdData = BUS_W'(lenRegs[busIdx]);
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/addrgen.sv
module addrgen
  import addrgen_pkg::*;
#(
  parameter bit DUAL_MEM = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [1:0]        busFile,
  input  logic [SEL_W-1:0]  busIdx,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              accessEn,
  input  logic [SEL_W-1:0]  accPtr,
  input  logic [SEL_W-1:0]  accMod,
  input  logic              accToPm,
  input  logic              bitRevMode,
  output logic [ADDR_W-1:0] dmAddr,
  output logic              dmValid,
  output logic [ADDR_W-1:0] pmAddr,
  output logic              pmValid
);
  strobes_t                       stb;
  logic [NUM_PTR-1:0][ADDR_W-1:0] idxFile;
  logic [ADDR_W-1:0]              modCur;
  logic [ADDR_W-1:0]              lenCur;

  addrgen_ctrl #(.DUAL_MEM(DUAL_MEM)) u_ctrl (
    .busWrEn(busWrEn), .busFile(busFile), .busIdx(busIdx),
    .accessEn(accessEn), .accPtr(accPtr), .accMod(accMod),
    .accToPm(accToPm), .bitRevMode(bitRevMode), .stb(stb)
  );

  addrgen_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busFile(busFile), .busIdx(busIdx),
    .busWrData(busWrData), .busRdData(busRdData),
    .dmAddr(dmAddr), .dmValid(dmValid), .pmAddr(pmAddr), .pmValid(pmValid),
    .idxFile(idxFile), .modCur(modCur), .lenCur(lenCur)
  );
endmodule

// File: rtl/addrgen_chk.sv
module addrgen_chk
  import addrgen_pkg::*;
#(
  parameter bit DUAL_MEM = 1'b0
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busWrEn,
  input logic [1:0]                     busFile,
  input logic [SEL_W-1:0]               busIdx,
  input logic [BUS_W-1:0]               busRdData,
  input logic                           accessEn,
  input logic [SEL_W-1:0]               accPtr,
  input logic                           dmValid,
  input logic                           pmValid,
  input logic [ADDR_W-1:0]              dmAddr,
  input logic [ADDR_W-1:0]              pmAddr,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] idxFile,
  input logic [ADDR_W-1:0]              modCur,
  input logic [ADDR_W-1:0]              lenCur
);
  logic sameIdxWrite;
  assign sameIdxWrite = busWrEn && (busFile == 2'd0) && (busIdx == accPtr);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !(dmValid && pmValid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |-> (!dmValid && !pmValid && dmAddr == '0 && pmAddr == '0)); // R9

  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[BUS_W-1:ADDR_W] == '0); // R2

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && lenCur == '0 && !sameIdxWrite)
      |=> idxFile[$past(accPtr)] == $past(idxFile[accPtr] + modCur)); // R4

  generate
    if (!DUAL_MEM) begin : g_noPm
      AST_NO_PM_PORT: assert property (@(posedge clk) disable iff (!rstN)
        !pmValid); // R8
    end
  endgenerate
endmodule

bind addrgen addrgen_chk #(.DUAL_MEM(DUAL_MEM)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busFile(busFile), .busIdx(busIdx),
  .busRdData(busRdData), .accessEn(accessEn), .accPtr(accPtr),
  .dmValid(dmValid), .pmValid(pmValid), .dmAddr(dmAddr), .pmAddr(pmAddr),
  .idxFile(idxFile), .modCur(modCur), .lenCur(lenCur)
);

// File: tb/addrgen_test.sv
module addrgen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [1:0] busFile = 2'd0;
  logic [1:0] busIdx = 2'd0;
  logic [15:0] busWrData = '0;
  logic accessEn = 1'b0;
  logic [1:0] accPtr = 2'd0;
  logic [1:0] accMod = 2'd0;
  logic accToPm = 1'b0;
  logic bitRevMode = 1'b0;
  logic [15:0] rdA, rdB;
  logic [13:0] dmA, pmA, dmB, pmB;
  logic dvA, pvA, dvB, pvB;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addrgen #(.DUAL_MEM(1'b0)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busFile(busFile), .busIdx(busIdx),
    .busWrData(busWrData), .busRdData(rdA), .accessEn(accessEn), .accPtr(accPtr),
    .accMod(accMod), .accToPm(accToPm), .bitRevMode(bitRevMode),
    .dmAddr(dmA), .dmValid(dvA), .pmAddr(pmA), .pmValid(pvA)
  );

  addrgen #(.DUAL_MEM(1'b1)) uutDual (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busFile(busFile), .busIdx(busIdx),
    .busWrData(busWrData), .busRdData(rdB), .accessEn(accessEn), .accPtr(accPtr),
    .accMod(accMod), .accToPm(accToPm), .bitRevMode(bitRevMode),
    .dmAddr(dmB), .dmValid(dvB), .pmAddr(pmB), .pmValid(pvB)
  );

  // walk of pointer 0 in a 5-word buffer at 0x100: {modify select, expected address}
  localparam logic [15:0] WALK [8] = '{
    {2'd0, 14'h100}, {2'd0, 14'h102}, {2'd1, 14'h104}, {2'd0, 14'h101},
    {2'd0, 14'h103}, {2'd1, 14'h100}, {2'd1, 14'h102}, {2'd0, 14'h104}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] f, input logic [1:0] i, input logic [15:0] d);
    busWrEn = 1'b1; busFile = f; busIdx = i; busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic readSel(input logic [1:0] f, input logic [1:0] i);
    busFile = f; busIdx = i;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readSel(2'd0, 2'd0); check("R1 index0", rdA, 16'h0);
    readSel(2'd1, 2'd3); check("R1 modify3", rdA, 16'h0);
    readSel(2'd2, 2'd2); check("R1 length2", rdA, 16'h0);

    // setup and R2 readback
    busWrite(2'd1, 2'd0, 16'h0002);
    busWrite(2'd1, 2'd1, 16'hFFFD);
    readSel(2'd1, 2'd1); check("R2 upper bits dropped", rdA, 16'h3FFD);
    busWrite(2'd2, 2'd0, 16'h0005);
    busWrite(2'd0, 2'd0, 16'h0100);
    busWrite(2'd3, 2'd0, 16'h1234);
    readSel(2'd3, 2'd0); check("R2 file code 3 reads zero", rdA, 16'h0);
    readSel(2'd0, 2'd0); check("R2 index unaffected by code 3", rdA, 16'h0100);

    // table walk: R3, R5, R10
    for (int n = 0; n < 8; n++) begin
      accessEn = 1'b1; accPtr = 2'd0; accMod = WALK[n][15:14];
      #1;
      check("R3 R5 R10 walk address", {2'b00, dmA}, {2'b00, WALK[n][13:0]});
      check("R3 walk valid", {15'h0, dvA}, 16'h1);
      tick();
      accessEn = 1'b0;
    end
    readSel(2'd0, 2'd0); check("R5 final wrapped index", rdA, 16'h0101);

    // R4 linear with modulo wrap
    busWrite(2'd0, 2'd1, 16'h3FFE);
    busWrite(2'd1, 2'd2, 16'h0003);
    accessEn = 1'b1; accPtr = 2'd1; accMod = 2'd2;
    #1; check("R3 pre-modify address", {2'b00, dmA}, 16'h3FFE);
    tick(); accessEn = 1'b0;
    readSel(2'd0, 2'd1); check("R4 linear modulo step", rdA, 16'h0001);

    // R9 idle
    #1;
    check("R9 dm valid low", {15'h0, dvA}, 16'h0);
    check("R9 pm valid low", {15'h0, pvB}, 16'h0);
    check("R9 dm address zero", {2'b00, dmA}, 16'h0);
    tick();
    readSel(2'd0, 2'd1); check("R9 index held", rdA, 16'h0001);

    // R6 collision
    accessEn = 1'b1; accPtr = 2'd1; accMod = 2'd2;
    busWrEn = 1'b1; busFile = 2'd0; busIdx = 2'd1; busWrData = 16'h0055;
    tick();
    accessEn = 1'b0; busWrEn = 1'b0;
    readSel(2'd0, 2'd1); check("R6 bus write wins", rdA, 16'h0055);

    // R7 bit reversal on data-only variant, R8 ignored on dual
    busWrite(2'd0, 2'd2, 16'h0001);
    bitRevMode = 1'b1; accessEn = 1'b1; accPtr = 2'd2; accMod = 2'd0;
    #1;
    check("R7 reversed address", {2'b00, dmA}, 16'h2000);
    check("R8 dual ignores reversal", {2'b00, dmB}, 16'h0001);
    tick();
    accessEn = 1'b0; bitRevMode = 1'b0;
    readSel(2'd0, 2'd2); check("R7 stored index not reversed", rdA, 16'h0003);

    // R8 memory routing
    busWrite(2'd0, 2'd3, 16'h0010);
    accToPm = 1'b1; accessEn = 1'b1; accPtr = 2'd3; accMod = 2'd0;
    #1;
    check("R8 dual pm valid", {15'h0, pvB}, 16'h1);
    check("R8 dual pm address", {2'b00, pmB}, 16'h0010);
    check("R8 dual dm valid low", {15'h0, dvB}, 16'h0);
    check("R8 data-only stays on dm", {15'h0, dvA}, 16'h1);
    check("R8 data-only pm valid low", {15'h0, pvA}, 16'h0);
    tick();
    accToPm = 1'b0;
    #1;
    check("R8 dual dm address after step", {2'b00, dmB}, 16'h0012);
    check("R8 dual dm valid", {15'h0, dvB}, 16'h1);
    tick();
    accessEn = 1'b0;

    finishRun();
  end
endmodule